// File: doc/BRIEF.md
# Digital Delta Modulation Codec

This block turns a stream of signed two's-complement samples into a one-bit-per-sample bitstream, and turns that bitstream back into samples. On each sample enable the coder compares the incoming sample with its own running reconstruction. It registers a single decision bit, which is 1 when the input lies above the reconstruction. It then moves the reconstruction up or down through a reference integrator that is driven by that decision.

The decoder is an independent copy of the same integrator. It is fed the bitstream and its own enable. Over an error-free channel it reproduces the coder's reconstruction exactly, sample for sample.

A parameter selects the reference path. Single mode uses one accumulator stepping by a fixed amount. Double mode uses two cascaded accumulators, which gives a smoother reconstruction. Both accumulators saturate at the sample range. A flag reports slope overload when a run of identical bits shows that the reconstruction cannot keep up with the input.

Top module: `dm_codec`

## Requirements
- R1: While rst_ni is low, all integrators, the output bit, the overload flag and the run count return to zero, so recon_o, rec_o, bit_o and ovl_o all read 0.
- R2: On a cycle with smp_en_i high, bit_o takes the value 1 if smp_i is greater than the current recon_o (both signed), and 0 otherwise; equality gives 0.
- R3: In single mode (MODE = INT_SINGLE), each enabled update adds STEP to the reconstruction for a 1 decision and subtracts STEP for a 0 decision.
- R4: In double mode (MODE = INT_DOUBLE), each enabled update first moves an inner accumulator by +STEP or -STEP. The saturated inner result is then added into an outer accumulator, and the outer accumulator is the reconstruction.
- R5: Every accumulator saturates at -2^(DW-1) and 2^(DW-1)-1 and never wraps.
- R6: Without an enable, the coder holds bit_o, recon_o and ovl_o, and the decoder holds rec_o.
- R7: A decoder fed with the coder's bits, one update per coder update, shows on rec_o the same value that recon_o showed after the matching coder update.
- R8: ovl_o is 1 exactly when the last K registered bits (K >= 2) are all equal. It falls on the first update whose bit differs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| smp_en_i | input | 1 | Coder sample enable |
| smp_i | input | DW | Signed input sample |
| bit_o | output | 1 | Registered decision bit (bitstream) |
| recon_o | output | DW | Coder reconstruction |
| ovl_o | output | 1 | Slope-overload flag |
| rx_en_i | input | 1 | Decoder bit enable |
| rx_bit_i | input | 1 | Received bitstream bit |
| rec_o | output | DW | Decoder recovered sample |

## Verification
A constant zero input makes the coder settle into alternating bits around zero. This separates a correct comparison, which sends equality to 0, from an off-by-one one, and it must never raise the overload flag. Inputs held at the positive and negative extremes drive long runs of equal bits. These runs expose saturation against wrap-around and show when the flag rises and falls. A slow ramp and seeded random samples, driven through a single-integrator instance and a double-integrator instance, separate the two reference paths and show that the decoder tracks the coder. Idle cycles between samples, and a reset late in the run, confirm the hold behaviour and the return to zero.

// File: rtl/dm_pkg.sv
package dm_pkg;

  typedef enum logic {
    INT_SINGLE = 1'b0,
    INT_DOUBLE = 1'b1
  } int_mode_e;

endpackage

// File: rtl/dm_integ.sv
module dm_integ
  import dm_pkg::*;
#(
  parameter int        DW   = 12,
  parameter int        STEP = 16,
  parameter int_mode_e MODE = INT_SINGLE
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic                 bit_i,
  output logic signed [DW-1:0] val_o
);

  localparam int EW = DW + 2;
  localparam logic signed [EW-1:0] MAX_E  = EW'((2 ** (DW - 1)) - 1);
  localparam logic signed [EW-1:0] MIN_E  = EW'(-(2 ** (DW - 1)));
  localparam logic signed [EW-1:0] STEP_E = EW'(STEP);
  localparam logic signed [DW-1:0] MAX_V  = MAX_E[DW-1:0];
  localparam logic signed [DW-1:0] MIN_V  = MIN_E[DW-1:0];

  function automatic logic signed [EW-1:0] ext(input logic signed [DW-1:0] v);
    return {{(EW - DW){v[DW-1]}}, v};
  endfunction

  function automatic logic signed [DW-1:0] clamp(input logic signed [EW-1:0] x);
    if (x > MAX_E) return MAX_V;
    if (x < MIN_E) return MIN_V;
    return x[DW-1:0];
  endfunction

  logic signed [DW-1:0] acc1_q, acc1_d;
  logic signed [EW-1:0] delta;

  always_comb begin
    delta  = bit_i ? STEP_E : -STEP_E;
    acc1_d = clamp(ext(acc1_q) + delta);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   acc1_q <= '0;
    else if (en_i) acc1_q <= acc1_d;
  end

  generate
    if (MODE == INT_DOUBLE) begin : g_double
      logic signed [DW-1:0] acc2_q, acc2_d;
      always_comb acc2_d = clamp(ext(acc2_q) + ext(acc1_d));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   acc2_q <= '0;
        else if (en_i) acc2_q <= acc2_d;
      end
      assign val_o = acc2_q;
    end else begin : g_single
      assign val_o = acc1_q;

      a_r5_no_wrap_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && bit_i && val_o == MAX_V) |=> (val_o == MAX_V));
      a_r5_no_wrap_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && !bit_i && val_o == MIN_V) |=> (val_o == MIN_V));
    end
  endgenerate

  a_r6_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(val_o));

endmodule

// File: rtl/dm_coder.sv
module dm_coder
  import dm_pkg::*;
#(
  parameter int        DW   = 12,
  parameter int        STEP = 16,
  parameter int_mode_e MODE = INT_SINGLE,
  parameter int        K    = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic signed [DW-1:0] smp_i,
  output logic                 bit_o,
  output logic signed [DW-1:0] recon_o,
  output logic                 ovl_o
);

  localparam int RW = $clog2(K + 1);
  localparam logic [RW-1:0] RUN_MAX = RW'(K);

  logic          dec;
  logic          bit_q;
  logic [RW-1:0] run_q;

  assign dec = (smp_i > recon_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q <= 1'b0;
      run_q <= '0;
    end else if (en_i) begin
      bit_q <= dec;
      if (run_q != '0 && dec == bit_q)
        run_q <= (run_q == RUN_MAX) ? RUN_MAX : run_q + 1'b1;
      else
        run_q <= RW'(1);
    end
  end

  dm_integ #(.DW(DW), .STEP(STEP), .MODE(MODE)) u_ref (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_i),
    .bit_i (dec),
    .val_o (recon_o)
  );

  assign bit_o = bit_q;
  assign ovl_o = (run_q == RUN_MAX);

  a_r6_bit_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(bit_o) && $stable(ovl_o)));
  a_r2_equal_is_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && smp_i == recon_o) |=> !bit_o);
  a_r8_rise_on_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovl_o) |-> $past(en_i));
  a_r8_drop_on_flip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovl_o && en_i && dec != bit_o) |=> !ovl_o);

endmodule

// File: rtl/dm_decoder.sv
module dm_decoder
  import dm_pkg::*;
#(
  parameter int        DW   = 12,
  parameter int        STEP = 16,
  parameter int_mode_e MODE = INT_SINGLE
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic                 bit_i,
  output logic signed [DW-1:0] rec_o
);

  dm_integ #(.DW(DW), .STEP(STEP), .MODE(MODE)) u_rx (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_i),
    .bit_i (bit_i),
    .val_o (rec_o)
  );

endmodule

// File: rtl/dm_codec.sv
module dm_codec
  import dm_pkg::*;
#(
  parameter int        DW   = 12,
  parameter int        STEP = 16,
  parameter int_mode_e MODE = INT_SINGLE,
  parameter int        K    = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          smp_en_i,
  input  logic [DW-1:0] smp_i,
  output logic          bit_o,
  output logic [DW-1:0] recon_o,
  output logic          ovl_o,
  input  logic          rx_en_i,
  input  logic          rx_bit_i,
  output logic [DW-1:0] rec_o
);

  logic signed [DW-1:0] recon_s, rec_s;

  dm_coder #(.DW(DW), .STEP(STEP), .MODE(MODE), .K(K)) u_cod (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (smp_en_i),
    .smp_i  ($signed(smp_i)),
    .bit_o  (bit_o),
    .recon_o(recon_s),
    .ovl_o  (ovl_o)
  );

  dm_decoder #(.DW(DW), .STEP(STEP), .MODE(MODE)) u_dec (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (rx_en_i),
    .bit_i (rx_bit_i),
    .rec_o (rec_s)
  );

  assign recon_o = recon_s;
  assign rec_o   = rec_s;

  a_r1_reset_zero: assert property (@(posedge clk_i)
    !rst_ni |-> (recon_o == '0 && rec_o == '0 && !bit_o && !ovl_o));

endmodule

// File: tb/sim_dm_codec.sv
`timescale 1ns/1ps
module sim_dm_codec;
  import dm_pkg::*;

  localparam int DW = 8;
  localparam int K  = 4;
  localparam int LO = -(2 ** (DW - 1));
  localparam int HI = (2 ** (DW - 1)) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_en = 1'b0;
  logic rx_en = 1'b0;
  logic [DW-1:0] smp = '0;

  logic b0, b1, o0, o1;
  logic [DW-1:0] rc0, rc1, rd0, rd1;

  int checks = 0;
  int fails  = 0;

  int st[2]  = '{8, 1};
  int dbl[2] = '{0, 1};
  int m_a1[2], m_a2[2], m_bit[2], m_run[2];

  always #2 clk = ~clk;

  dm_codec #(.DW(DW), .STEP(8), .MODE(INT_SINGLE), .K(K)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .smp_en_i(smp_en), .smp_i(smp),
    .bit_o(b0), .recon_o(rc0), .ovl_o(o0),
    .rx_en_i(rx_en), .rx_bit_i(b0), .rec_o(rd0));

  dm_codec #(.DW(DW), .STEP(1), .MODE(INT_DOUBLE), .K(K)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .smp_en_i(smp_en), .smp_i(smp),
    .bit_o(b1), .recon_o(rc1), .ovl_o(o1),
    .rx_en_i(rx_en), .rx_bit_i(b1), .rec_o(rd1));

  function automatic int sat(int x);
    if (x > HI) return HI;
    if (x < LO) return LO;
    return x;
  endfunction

  function automatic int sx(logic [DW-1:0] v);
    return int'($signed(v));
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 2; i++) begin
      m_a1[i] = 0; m_a2[i] = 0; m_bit[i] = 0; m_run[i] = 0;
    end
  endtask

  function automatic int m_rec(int i);
    return dbl[i] != 0 ? m_a2[i] : m_a1[i];
  endfunction

  task automatic model_step(int i, int s);
    int d;
    d = (s > m_rec(i)) ? 1 : 0;
    m_a1[i] = sat(m_a1[i] + (d != 0 ? st[i] : -st[i]));
    if (dbl[i] != 0) m_a2[i] = sat(m_a2[i] + m_a1[i]);
    if (m_run[i] != 0 && d == m_bit[i]) m_run[i] = (m_run[i] < K) ? m_run[i] + 1 : K;
    else m_run[i] = 1;
    m_bit[i] = d;
  endtask

  task automatic check_coder();
    chk("R2 bit u0", int'(b0), m_bit[0]);
    chk("R2 bit u1", int'(b1), m_bit[1]);
    chk("R3/R5 recon single", sx(rc0), m_rec(0));
    chk("R4/R5 recon double", sx(rc1), m_rec(1));
    chk("R8 ovl u0", int'(o0), (m_run[0] == K) ? 1 : 0);
    chk("R8 ovl u1", int'(o1), (m_run[1] == K) ? 1 : 0);
  endtask

  task automatic samp(int s);
    smp_en = 1'b1;
    smp = DW'(s);
    model_step(0, s);
    model_step(1, s);
    @(negedge clk);
    smp_en = 1'b0;
    rx_en = 1'b1;
    check_coder();
    @(negedge clk);
    rx_en = 1'b0;
    chk("R7 decoder single", sx(rd0), m_rec(0));
    chk("R7 decoder double", sx(rd1), m_rec(1));
    chk("R6 recon held single", sx(rc0), m_rec(0));
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [DW-1:0] r;
    void'($urandom(32'h5eed_0042));
    model_reset();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 recon", sx(rc0) | sx(rc1), 0);
    chk("R1 rec", sx(rd0) | sx(rd1), 0);
    chk("R1 bit/ovl", int'(b0 | b1 | o0 | o1), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // idle around zero: alternating bits, no overload
    for (int n = 0; n < 12; n++) samp(0);
    chk("R8 no ovl at rest", int'(o0), 0);
    // positive extreme: saturation high and overload
    for (int n = 0; n < 40; n++) samp(HI);
    chk("R5 top single", sx(rc0), HI);
    // flip to opposite extreme
    for (int n = 0; n < 60; n++) samp(LO);
    chk("R5 bottom single", sx(rc0), LO);

    // R6: idle cycles without enables
    for (int n = 0; n < 5; n++) begin
      smp = DW'(HI);
      @(negedge clk);
      chk("R6 hold recon", sx(rc0), m_rec(0));
      chk("R6 hold bit", int'(b1), m_bit[1]);
      chk("R6 hold rec", sx(rd1), m_rec(1));
    end

    // slow ramp
    for (int v = -100; v <= 100; v += 5) samp(v);
    // seeded random
    for (int n = 0; n < 300; n++) begin
      r = DW'($urandom());
      samp(sx(r));
    end
    // small random around current level
    for (int n = 0; n < 100; n++) samp(int'($urandom_range(0, 20)) - 10);

    // R1 reset late in the run
    rst_n = 1'b0;
    model_reset();
    @(negedge clk);
    chk("R1 late recon", sx(rc0) | sx(rc1), 0);
    chk("R1 late rec", sx(rd0) | sx(rd1), 0);
    chk("R1 late bit/ovl", int'(b0 | b1 | o0 | o1), 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int n = 0; n < 6; n++) samp(50);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule